// File: doc/BRIEF.md
# Masked Vector Compare-Subtract Unit

This block is a single-lane, element-serial vector engine. It holds one 64-element working vector of 64-bit integers and a 64-bit element mask. It runs three operations. A not-equal compare sets one mask bit per element, according to whether that element differs from a scalar. A masked subtract writes the difference of two vectors back only where the mask bit is set. An unmasked subtract writes every active element and ignores the mask.

The block handles one element per clock. A controller walks an element index from zero up to the active vector length and then raises a one-cycle completion pulse. An operation starts with a single-cycle `start_i`, sampled while the unit is idle. On that edge the working vector is loaded from `vec_a_i`, and the opcode, scalar and length are captured. `vec_b_i` must stay stable until completion. The mask persists from one operation to the next, so a compare sets up the gating for the subtract that follows.

The controller states are IDLE, RUN and FIN. The transitions are:
- IDLE to RUN on an accepted start with a non-zero length.
- IDLE to FIN on an accepted start with a zero length.
- RUN to RUN while the index is below the last active element.
- RUN to FIN after the last active element.
- FIN to IDLE unconditionally.

Top module: `mvec_cmpsub_unit`

## Requirements
- R1: After reset, `result_o` and `mask_o` are all zeros, and `busy_o` and `done_o` are low.
- R2: With opcode 2'b00 (compare), mask bit i becomes 1 when element i of `vec_a_i` differs from `scalar_i`, and 0 when they are equal, for every i below the active length. `result_o` becomes a copy of `vec_a_i`.
- R3: A compare leaves every mask bit at or above the active length unchanged.
- R4: With opcode 2'b01 (masked subtract), element i of `result_o` becomes a[i] - b[i] when i is below the active length and mask bit i is 1.
- R5: In a masked subtract, an element whose mask bit is 0, or whose index is at or above the active length, keeps the value loaded from `vec_a_i`.
- R6: With `op_i[1]` = 1 (unmasked subtract), every element below the active length becomes a[i] - b[i] whatever its mask bit. Neither subtract mode changes `mask_o`.
- R7: Subtraction wraps modulo 2^64.
- R8: If `start_i` is accepted at clock edge k, `done_o` is high for exactly one cycle, the cycle after edge k+L. L is the active length, which equals `len_i` clamped to 64, so a length of zero gives a pulse right after edge k. `busy_o` is high from edge k until the edge that ends the pulse.
- R9: `start_i` is ignored while `busy_o` is high. Length, opcode and working data all stay as captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; taken only when idle |
| op_i | input | 2 | 00 compare, 01 masked subtract, 1x unmasked subtract |
| len_i | input | 7 | Active vector length, clamped to 64 |
| scalar_i | input | 64 | Scalar operand of the compare |
| vec_a_i | input | 4096 | First vector, element i at bits [64i+63:64i]; loaded at start |
| vec_b_i | input | 4096 | Subtrahend vector, same layout; held until done |
| result_o | output | 4096 | Working vector, same layout |
| mask_o | output | 64 | Element mask, bit i for element i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The two functions that can collide in one cycle are the acceptance of a new start and the stepping of a running operation. A second `start_i`, carrying a different opcode, a short length and new `vec_a_i` data, is pulsed midway through a full-length compare. The run must still end on the cycle set by the original length, and its mask and result must match the first command only. A second collision happens at every run boundary, where the last element write and the completion pulse meet. It is judged by counting cycles to `done_o` and then checking that the pulse drops one cycle later.

// File: rtl/mvcs_pkg.sv
package mvcs_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIN  = 2'd2
    } seq_state_t;

    localparam logic [1:0] OP_CMP_NE = 2'b00;
    localparam logic [1:0] OP_SUB_MK = 2'b01;

endpackage

// File: rtl/mvcs_seq.sv
module mvcs_seq
    import mvcs_pkg::*;
#(
    parameter int NUM_ELEM = 64,
    parameter int IDX_W    = $clog2(NUM_ELEM),
    parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             load_o,
    output logic             step_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             done_o
);

    seq_state_t       st_q, st_d;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] len_q;
    logic             last_elem;

    assign last_elem = ({1'b0, idx_q} == (len_q - LEN_W'(1)));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start_i) st_d = (len_i == '0) ? S_FIN : S_RUN;
            S_RUN:  if (last_elem) st_d = S_FIN;
            S_FIN:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            idx_q <= '0;
            len_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE && start_i) begin
                idx_q <= '0;
                len_q <= len_i;
            end else if (st_q == S_RUN && !last_elem) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        idx_o  = idx_q;
        unique case (st_q)
            S_IDLE: load_o = start_i;
            S_RUN:  begin step_o = 1'b1; busy_o = 1'b1; end
            S_FIN:  begin done_o = 1'b1; busy_o = 1'b1; end
            default: ;
        endcase
    end

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: a running operation advances its index one step and is never restarted
    p_idx_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN && !last_elem) |=>
            (st_q == S_RUN && idx_q == IDX_W'($past(idx_q) + 1'b1)));

endmodule

// File: rtl/mvcs_elem_alu.sv
module mvcs_elem_alu #(
    parameter int ELEM_W = 64
) (
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    input  logic [ELEM_W-1:0] scalar_i,
    output logic              ne_o,
    output logic [ELEM_W-1:0] diff_o
);

    assign ne_o   = (a_i != scalar_i);
    assign diff_o = a_i - b_i;

endmodule

// File: rtl/mvec_cmpsub_unit.sv
module mvec_cmpsub_unit
    import mvcs_pkg::*;
#(
    parameter int NUM_ELEM = 64,
    parameter int ELEM_W   = 64,
    parameter int IDX_W    = $clog2(NUM_ELEM),
    parameter int LEN_W    = $clog2(NUM_ELEM + 1),
    parameter int VEC_W    = NUM_ELEM * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ELEM_W-1:0] scalar_i,
    input  logic [VEC_W-1:0]  vec_a_i,
    input  logic [VEC_W-1:0]  vec_b_i,
    output logic [VEC_W-1:0]  result_o,
    output logic [NUM_ELEM-1:0] mask_o,
    output logic              busy_o,
    output logic              done_o
);

    logic [ELEM_W-1:0]   work_q [NUM_ELEM];
    logic [ELEM_W-1:0]   a_arr  [NUM_ELEM];
    logic [ELEM_W-1:0]   b_arr  [NUM_ELEM];
    logic [NUM_ELEM-1:0] mask_q;
    logic [ELEM_W-1:0]   scalar_q;
    logic                is_cmp_q, unmask_q;
    logic [LEN_W-1:0]    len_eff;
    logic                load, step;
    logic [IDX_W-1:0]    idx;
    logic                elem_ne;
    logic [ELEM_W-1:0]   elem_diff;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ELEM; gi++) begin : g_slice
            assign a_arr[gi] = vec_a_i[gi*ELEM_W +: ELEM_W];
            assign b_arr[gi] = vec_b_i[gi*ELEM_W +: ELEM_W];
            assign result_o[gi*ELEM_W +: ELEM_W] = work_q[gi];
        end
    endgenerate

    assign len_eff = (len_i > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : len_i;

    mvcs_seq #(
        .NUM_ELEM (NUM_ELEM),
        .IDX_W    (IDX_W),
        .LEN_W    (LEN_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .len_i   (len_eff),
        .load_o  (load),
        .step_o  (step),
        .idx_o   (idx),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mvcs_elem_alu #(
        .ELEM_W (ELEM_W)
    ) u_alu (
        .a_i      (work_q[idx]),
        .b_i      (b_arr[idx]),
        .scalar_i (scalar_q),
        .ne_o     (elem_ne),
        .diff_o   (elem_diff)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ELEM; i++) work_q[i] <= '0;
            mask_q   <= '0;
            scalar_q <= '0;
            is_cmp_q <= 1'b0;
            unmask_q <= 1'b0;
        end else if (load) begin
            for (int i = 0; i < NUM_ELEM; i++) work_q[i] <= a_arr[i];
            scalar_q <= scalar_i;
            is_cmp_q <= (op_i == OP_CMP_NE);
            unmask_q <= op_i[1];
        end else if (step) begin
            if (is_cmp_q)
                mask_q[idx] <= elem_ne;
            else if (unmask_q || mask_q[idx])
                work_q[idx] <= elem_diff;
        end
    end

    assign mask_o = mask_q;

    // R6: subtract modes never touch the mask
    p_mask_hold_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !is_cmp_q) |=> $stable(mask_o));

    // R5: a disabled element step leaves the working vector untouched
    p_keep_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !is_cmp_q && !unmask_q && !mask_o[idx]) |=> $stable(result_o));

    // R2: a compare step writes only the mask, never the data
    p_cmp_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && is_cmp_q) |=> $stable(result_o));

endmodule

// File: tb/mvec_cmpsub_unit_bench.sv
module mvec_cmpsub_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 64;
    localparam int W = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [1:0]     op_i = 2'b00;
    logic [6:0]     len_i = '0;
    logic [W-1:0]   scalar_i = '0;
    logic [N*W-1:0] vec_a_i, vec_b_i, result_o;
    logic [N-1:0]   mask_o;
    logic           busy_o, done_o;

    logic [W-1:0] a_m [N];
    logic [W-1:0] b_m [N];
    logic [W-1:0] exp_res [N];
    logic [N-1:0] exp_mask;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            vec_a_i[i*W +: W] = a_m[i];
            vec_b_i[i*W +: W] = b_m[i];
        end
    end

    mvec_cmpsub_unit u_mvec_cmpsub_unit (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .op_i (op_i),
        .len_i (len_i), .scalar_i (scalar_i), .vec_a_i (vec_a_i),
        .vec_b_i (vec_b_i), .result_o (result_o), .mask_o (mask_o),
        .busy_o (busy_o), .done_o (done_o)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++)
            check(result_o[i*W +: W] == exp_res[i], tag, result_o[i*W +: W], exp_res[i]);
        check(mask_o == exp_mask, {tag, " mask"}, mask_o, exp_mask);
    endtask

    // model of compare and subtract, from the requirements
    task automatic model(input logic [1:0] op, input int len, input logic [W-1:0] s);
        int l = (len > N) ? N : len;
        for (int i = 0; i < N; i++) begin
            exp_res[i] = a_m[i];
            if (i < l) begin
                if (op == 2'b00)
                    exp_mask[i] = (a_m[i] != s);
                else if (op[1] || exp_mask[i])
                    exp_res[i] = a_m[i] - b_m[i];
            end
        end
    endtask

    // start, count cycles to done (R8), confirm the pulse drops
    task automatic run_op(input logic [1:0] op, input int len, input logic [W-1:0] s,
                          input string tag);
        int j = 0;
        int l = (len > N) ? N : len;
        @(negedge clk);
        op_i = op; len_i = 7'(len); scalar_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && j < 300) begin @(negedge clk); j++; end
        check(j == l, {tag, " R8 latency"}, W'(j), W'(l));
        model(op, len, s);
        check_all(tag);
        @(negedge clk);
        check(!done_o, {tag, " R8 single pulse"}, W'(done_o), '0);
    endtask

    task automatic fill(input logic [W-1:0] seed, input logic [W-1:0] s);
        for (int i = 0; i < N; i++) begin
            a_m[i] = (i % 3 == 0) ? s : (W'(i) * 64'h9E37_79B9_7F4A_7C15) ^ seed;
            b_m[i] = (W'(i) * 64'h0000_0100_0000_0003) + seed;
        end
    endtask

    task automatic t_reset();
        check(result_o == '0, "R1 result", result_o[W-1:0], '0);
        check(mask_o == '0, "R1 mask", mask_o, '0);
        check(!busy_o && !done_o, "R1 busy/done", W'({busy_o, done_o}), '0);
        for (int i = 0; i < N; i++) exp_res[i] = '0;
        exp_mask = '0;
    endtask

    task automatic t_cmp_full();
        fill(64'h1111, 64'hDEAD_BEEF);
        run_op(2'b00, 64, 64'hDEAD_BEEF, "R2 compare full");
    endtask

    task automatic t_sub_masked_wrap();
        a_m[1] = 64'd5; b_m[1] = 64'd9;  // R7 wrap: 5 - 9
        run_op(2'b01, 64, '0, "R4 R5 R7 masked sub");
        check(result_o[1*W +: W] == 64'hFFFF_FFFF_FFFF_FFFC, "R7 wrap",
              result_o[1*W +: W], 64'hFFFF_FFFF_FFFF_FFFC);
    endtask

    task automatic t_cmp_short();
        fill(64'h2222, 64'h77);
        for (int i = 0; i < N; i++) a_m[i] = (i < 10 && i % 2 == 0) ? 64'h77 : ~W'(i);
        run_op(2'b00, 10, 64'h77, "R3 compare short");
    endtask

    task automatic t_sub_short();
        run_op(2'b01, 20, '0, "R5 masked sub short");
    endtask

    task automatic t_sub_unmasked();
        fill(64'h3333, '0);
        run_op(2'b10, 64, '0, "R6 unmasked sub");
        run_op(2'b11, 33, '0, "R6 unmasked sub 11");
    endtask

    task automatic t_len_zero();
        fill(64'h4444, '0);
        run_op(2'b10, 0, '0, "R8 zero length");
    endtask

    task automatic t_len_clamp();
        run_op(2'b00, 100, 64'h5, "R8 clamped length");
    endtask

    task automatic t_start_busy();
        int j = 0;
        fill(64'h5555, 64'hABC);
        model(2'b00, 64, 64'hABC);
        @(negedge clk);
        op_i = 2'b00; len_i = 7'd64; scalar_i = 64'hABC; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) begin @(negedge clk); j++; end
        op_i = 2'b10; len_i = 7'd5; scalar_i = '0; start_i = 1'b1;
        for (int i = 0; i < N; i++) a_m[i] = '1;
        @(negedge clk); j++;
        start_i = 1'b0;
        while (!done_o && j < 300) begin @(negedge clk); j++; end
        check(j == 64, "R9 ignored start latency", W'(j), 64);
        check_all("R9 ignored start");
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin a_m[i] = '0; b_m[i] = '0; end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cmp_full();
        t_sub_masked_wrap();
        t_cmp_short();
        t_sub_short();
        t_sub_unmasked();
        t_len_zero();
        t_len_clamp();
        t_start_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule